// File: doc/BRIEF.md
# Single-Car Elevator Scheduler

This block schedules one elevator car in a building with two basement stops and twenty floors above ground, 22 stops in all. It takes three request vectors: buttons pressed inside the car, hall calls to go up, and hall calls to go down. A per-car service mode first removes every request the car is not allowed to serve. A seven-state machine then decides whether the car stands, moves or opens its door.

Everything runs on one system clock. The machine advances only in cycles where the single-cycle `tick_en` input is high, and each advance moves the car by at most one stop. Once the car has picked a direction it keeps going that way while any allowed request lies further along. It stops at floors that match its direction, reverses only when nothing is left ahead, and falls back to an idle state when no allowed request remains anywhere. Clearing requests once they are served is left to the surrounding logic.

Top module: `lift_car_ctrl`

## Requirements
- R1: After reset the car is at floor 1 (position bit 2) in the idle state. The state output is one-hot with bit 0 idle, bit 1 moving up, bit 2 moving down, bit 3 stopping on the way up, bit 4 stopping on the way down, bit 5 door open and bit 6 door closing.
- R2: The position output is always one-hot, with bit 0 = B2, bit 1 = B1 and bit k = floor k-1 for k ≥ 2. When it changes, it shifts by exactly one place: left when moving up, right when moving down.
- R3: Position and state change only on a clock edge where `tick_en` is high.
- R4: `svc_mode` selects which stops count: 0 all stops; 1 odd floors plus B2, B1 and floor 1; 2 even floors plus B2 and B1; 3 B2 through floor 10; 4 floors 10 to 20 plus B2, B1 and floor 1; codes 5 to 7 behave as 0. A request at a stop the mode excludes has no effect.
- R5: `hall_up[21]` (no up button at floor 20) and `hall_dn[0]` (no down button at B2) are ignored.
- R6: In the idle state, car-button requests decide before hall calls. A request at the current stop opens the door, one above moves the car up, and one below moves it down.
- R7: While moving up, the car enters the up-stop state at a stop with a car request or an up call. While moving down, it enters the down-stop state at a stop with a car request or a down call. Either stop state goes to door open on the next tick.
- R8: The door-open state lasts exactly `DOOR_TICKS` (default 5) ticks and is then followed by door closing.
- R9: After the door closes, the car continues in its previous direction whenever any allowed request lies ahead in that direction, even if a request in the other direction is nearer.
- R10: With no allowed request anywhere, a moving or closing car goes to idle on the next tick and stays there.
- R11: The car never moves below B2 or above floor 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle pulse that lets the scheduler advance |
| svc_mode | input | 3 | Service-mode code (see R4) |
| car_req | input | 22 | Car-button requests, one bit per stop |
| hall_up | input | 22 | Up hall calls; bit 21 is ignored |
| hall_dn | input | 22 | Down hall calls; bit 0 is ignored |
| car_pos | output | 22 | One-hot car position |
| car_state | output | 7 | One-hot scheduler state |

## Verification
The properties assume that requests and mode are ordinary levels held by the caller, and that `tick_en` is a clean pulse. They make no assumption on how requests change between ticks, because each one relates the outputs only to the tick that caused the change. The stimulus raises `tick_en` for one cycle at a time, separated by a random number of quiet cycles. It changes requests and mode only in cycles without a tick, so the idle-hold property is exercised on every gap. Random request patterns are kept sparse and are cleared now and then, so the car goes through full trips, turnarounds and returns to idle, and does not reopen at a single stop forever.

// File: rtl/lift_pkg.sv
package lift_pkg;

   typedef enum logic [6:0] {
      ST_IDLE   = 7'b0000001,
      ST_RISE   = 7'b0000010,
      ST_FALL   = 7'b0000100,
      ST_RSTOP  = 7'b0001000,
      ST_FSTOP  = 7'b0010000,
      ST_OPEN   = 7'b0100000,
      ST_CLOSE  = 7'b1000000
   } lift_state_e;

   typedef enum logic [1:0] {
      DIR_NONE = 2'd0,
      DIR_RISE = 2'd1,
      DIR_FALL = 2'd2
   } lift_dir_e;

   localparam logic [2:0] SVC_ALL  = 3'd0;
   localparam logic [2:0] SVC_ODD  = 3'd1;
   localparam logic [2:0] SVC_EVEN = 3'd2;
   localparam logic [2:0] SVC_LOW  = 3'd3;
   localparam logic [2:0] SVC_HIGH = 3'd4;

endpackage

// File: rtl/lift_service_mask.sv
module lift_service_mask
   import lift_pkg::*;
#(
   parameter int N_BASE     = 2,
   parameter int N_FLOOR    = 20,
   parameter int ZONE_SPLIT = 10,
   localparam int N_STOPS   = N_BASE + N_FLOOR
) (
   input  logic [2:0]         svc_mode,
   input  logic [N_STOPS-1:0] car_in,
   input  logic [N_STOPS-1:0] up_in,
   input  logic [N_STOPS-1:0] dn_in,
   output logic [N_STOPS-1:0] car_out,
   output logic [N_STOPS-1:0] up_out,
   output logic [N_STOPS-1:0] dn_out
);

   logic [N_STOPS-1:0] allow;

   for (genvar i = 0; i < N_STOPS; i++) begin : g_stop
      // floor number seen by passengers; zero or negative below ground
      localparam int FL = i - N_BASE + 1;
      localparam bit OK_ODD  = (i <= N_BASE) || (FL % 2 == 1);
      localparam bit OK_EVEN = (i < N_BASE) || ((FL > 0) && (FL % 2 == 0));
      localparam bit OK_LOW  = (FL <= ZONE_SPLIT);
      localparam bit OK_HIGH = (i <= N_BASE) || (FL >= ZONE_SPLIT);

      always_comb begin
         unique case (svc_mode)
            SVC_ODD:  allow[i] = OK_ODD;
            SVC_EVEN: allow[i] = OK_EVEN;
            SVC_LOW:  allow[i] = OK_LOW;
            SVC_HIGH: allow[i] = OK_HIGH;
            default:  allow[i] = 1'b1;
         endcase
      end

      assign car_out[i] = car_in[i] & allow[i];

      if (i < N_STOPS - 1) begin : g_up
         assign up_out[i] = up_in[i] & allow[i];
      end else begin : g_no_up
         // the top stop has no up button: the bit is read and discarded
         assign up_out[i] = up_in[i] & 1'b0;
      end

      if (i > 0) begin : g_dn
         assign dn_out[i] = dn_in[i] & allow[i];
      end else begin : g_no_dn
         // the bottom stop has no down button
         assign dn_out[i] = dn_in[i] & 1'b0;
      end
   end

endmodule

// File: rtl/lift_reach_scan.sv
module lift_reach_scan #(
   parameter int N_STOPS = 22
) (
   input  logic [N_STOPS-1:0] pos,
   input  logic [N_STOPS-1:0] vec,
   output logic               above,
   output logic               below
);

   logic [N_STOPS-1:0] over_m;
   logic [N_STOPS-1:0] under_m;

   // over_m[i] marks stops strictly above the car, under_m[i] strictly below
   always_comb begin
      logic seen_lo;
      logic seen_hi;
      seen_lo = 1'b0;
      for (int i = 0; i < N_STOPS; i++) begin
         over_m[i] = seen_lo;
         seen_lo   = seen_lo | pos[i];
      end
      seen_hi = 1'b0;
      for (int i = N_STOPS - 1; i >= 0; i--) begin
         under_m[i] = seen_hi;
         seen_hi    = seen_hi | pos[i];
      end
   end

   assign above = |(vec & over_m);
   assign below = |(vec & under_m);

endmodule

// File: rtl/lift_door_timer.sv
module lift_door_timer #(
   parameter int DOOR_TICKS = 5,
   localparam int CNT_W     = $clog2(DOOR_TICKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic door_open,
   output logic expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (tick_en) begin
         if (door_open) cnt <= cnt + 1'b1;
         else           cnt <= '0;
      end
   end

   assign expired = door_open && (cnt == CNT_W'(DOOR_TICKS - 1));

endmodule

// File: rtl/lift_car_ctrl.sv
module lift_car_ctrl
   import lift_pkg::*;
#(
   parameter int N_BASE     = 2,
   parameter int N_FLOOR    = 20,
   parameter int ZONE_SPLIT = 10,
   parameter int DOOR_TICKS = 5,
   localparam int N_STOPS   = N_BASE + N_FLOOR,
   localparam int HOME      = N_BASE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_en,
   input  logic [2:0]         svc_mode,
   input  logic [N_STOPS-1:0] car_req,
   input  logic [N_STOPS-1:0] hall_up,
   input  logic [N_STOPS-1:0] hall_dn,
   output logic [N_STOPS-1:0] car_pos,
   output logic [6:0]         car_state
);

   if (N_BASE < 0 || N_FLOOR < 2) begin : g_bad_size
      $error("lift_car_ctrl: need at least two floors above ground");
   end
   if (DOOR_TICKS < 1) begin : g_bad_door
      $error("lift_car_ctrl: DOOR_TICKS must be at least 1");
   end
   if (ZONE_SPLIT < 1 || ZONE_SPLIT > N_FLOOR) begin : g_bad_zone
      $error("lift_car_ctrl: ZONE_SPLIT must name a floor above ground");
   end

   localparam int SCAN_N   = 3;
   localparam int SC_CAR   = 0;
   localparam int SC_HALL  = 1;
   localparam int SC_ALL   = 2;

   logic [N_STOPS-1:0] eff_car, eff_up, eff_dn;
   logic [N_STOPS-1:0] pos_q;
   lift_state_e        state_q, state_d;
   lift_dir_e          dir_q;
   logic               door_done;

   lift_service_mask #(
      .N_BASE     (N_BASE),
      .N_FLOOR    (N_FLOOR),
      .ZONE_SPLIT (ZONE_SPLIT)
   ) u_mask (
      .svc_mode (svc_mode),
      .car_in   (car_req),
      .up_in    (hall_up),
      .dn_in    (hall_dn),
      .car_out  (eff_car),
      .up_out   (eff_up),
      .dn_out   (eff_dn)
   );

   // requests relative to the car: car buttons, hall calls, everything
   logic [N_STOPS-1:0] scan_vec [SCAN_N];
   logic [SCAN_N-1:0]  scan_above;
   logic [SCAN_N-1:0]  scan_below;

   assign scan_vec[SC_CAR]  = eff_car;
   assign scan_vec[SC_HALL] = eff_up | eff_dn;
   assign scan_vec[SC_ALL]  = eff_car | eff_up | eff_dn;

   for (genvar s = 0; s < SCAN_N; s++) begin : g_scan
      lift_reach_scan #(.N_STOPS(N_STOPS)) u_scan (
         .pos   (pos_q),
         .vec   (scan_vec[s]),
         .above (scan_above[s]),
         .below (scan_below[s])
      );
   end

   logic car_here, up_here, dn_here;
   logic any_above, any_below;

   assign car_here  = |(eff_car & pos_q);
   assign up_here   = |(eff_up & pos_q);
   assign dn_here   = |(eff_dn & pos_q);
   assign any_above = scan_above[SC_ALL];
   assign any_below = scan_below[SC_ALL];

   lift_door_timer #(.DOOR_TICKS(DOOR_TICKS)) u_door (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .door_open (state_q == ST_OPEN),
      .expired   (door_done)
   );

   // choice from rest: car buttons first, then hall calls
   lift_state_e idle_pick;
   always_comb begin
      if (car_here)                    idle_pick = ST_OPEN;
      else if (scan_above[SC_CAR])     idle_pick = ST_RISE;
      else if (scan_below[SC_CAR])     idle_pick = ST_FALL;
      else if (up_here || dn_here)     idle_pick = ST_OPEN;
      else if (scan_above[SC_HALL])    idle_pick = ST_RISE;
      else if (scan_below[SC_HALL])    idle_pick = ST_FALL;
      else                             idle_pick = ST_IDLE;
   end

   // continuing choices for each direction; stop_st is the state used to halt
   function automatic lift_state_e go_rise(input logic stop_match,
                                           input logic turn_match,
                                           input lift_state_e stop_st,
                                           input lift_state_e turn_st,
                                           input logic ahead, input logic behind);
      if (stop_match)      return stop_st;
      else if (ahead)      return ST_RISE;
      else if (turn_match) return turn_st;
      else if (behind)     return ST_FALL;
      else                 return ST_IDLE;
   endfunction

   function automatic lift_state_e go_fall(input logic stop_match,
                                           input logic turn_match,
                                           input lift_state_e stop_st,
                                           input lift_state_e turn_st,
                                           input logic ahead, input logic behind);
      if (stop_match)      return stop_st;
      else if (ahead)      return ST_FALL;
      else if (turn_match) return turn_st;
      else if (behind)     return ST_RISE;
      else                 return ST_IDLE;
   endfunction

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  state_d = idle_pick;
         ST_RISE:  state_d = go_rise(car_here | up_here, dn_here,
                                     ST_RSTOP, ST_FSTOP, any_above, any_below);
         ST_FALL:  state_d = go_fall(car_here | dn_here, up_here,
                                     ST_FSTOP, ST_RSTOP, any_below, any_above);
         ST_RSTOP: state_d = ST_OPEN;
         ST_FSTOP: state_d = ST_OPEN;
         ST_OPEN:  state_d = door_done ? ST_CLOSE : ST_OPEN;
         ST_CLOSE: begin
            unique case (dir_q)
               DIR_RISE: state_d = go_rise(car_here | up_here, dn_here,
                                           ST_OPEN, ST_OPEN, any_above, any_below);
               DIR_FALL: state_d = go_fall(car_here | dn_here, up_here,
                                           ST_OPEN, ST_OPEN, any_below, any_above);
               default:  state_d = idle_pick;
            endcase
         end
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dir_q   <= DIR_NONE;
         pos_q   <= N_STOPS'(1) << HOME;
      end else if (tick_en) begin
         state_q <= state_d;
         unique case (state_d)
            ST_RISE: begin
               dir_q <= DIR_RISE;
               if (!pos_q[N_STOPS-1]) pos_q <= pos_q << 1;
            end
            ST_FALL: begin
               dir_q <= DIR_FALL;
               if (!pos_q[0]) pos_q <= pos_q >> 1;
            end
            ST_RSTOP: dir_q <= DIR_RISE;
            ST_FSTOP: dir_q <= DIR_FALL;
            ST_IDLE:  dir_q <= DIR_NONE;
            default:  dir_q <= dir_q;
         endcase
      end
   end

   assign car_pos   = pos_q;
   assign car_state = state_q;

endmodule

// File: rtl/lift_car_ctrl_chk.sv
module lift_car_ctrl_chk
   import lift_pkg::*;
#(
   parameter int N_STOPS    = 22,
   parameter int DOOR_TICKS = 5,
   localparam int CNT_W     = $clog2(DOOR_TICKS + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick_en,
   input logic [N_STOPS-1:0] car_pos,
   input logic [6:0]         car_state
);

   logic [CNT_W-1:0] open_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       open_cnt <= '0;
      else if (tick_en) open_cnt <= (car_state == ST_OPEN) ? open_cnt + 1'b1 : '0;
   end

   a_r2_pos_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(car_pos) == 1);

   a_r1_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(car_state) == 1);

   a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(car_pos) && $stable(car_state));

   a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(car_pos) |-> (car_pos == ($past(car_pos) << 1)) ||
                            (car_pos == ($past(car_pos) >> 1)));

   a_r11_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
      car_pos[N_STOPS-1] |=> !car_pos[0]);

   a_r7_stop_to_open: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && (car_state == ST_RSTOP || car_state == ST_FSTOP))
      |=> car_state == ST_OPEN);

   a_r8_door_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && car_state == ST_OPEN && open_cnt < CNT_W'(DOOR_TICKS - 1))
      |=> car_state == ST_OPEN);

   a_r8_door_close: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && car_state == ST_OPEN && open_cnt == CNT_W'(DOOR_TICKS - 1))
      |=> car_state == ST_CLOSE);

endmodule

bind lift_car_ctrl lift_car_ctrl_chk #(
   .N_STOPS    (N_STOPS),
   .DOOR_TICKS (DOOR_TICKS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .car_pos   (car_pos),
   .car_state (car_state)
);

// File: tb/lift_car_ctrl_test.sv
`timescale 1ns/1ps
module lift_car_ctrl_test;

   localparam int NS = 22;
   localparam int DT = 5;
   // state indices, bit position in car_state
   localparam int S_IDLE = 0, S_RISE = 1, S_FALL = 2, S_RSTOP = 3,
                  S_FSTOP = 4, S_OPEN = 5, S_CLOSE = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic [2:0]    svc_mode = 3'd0;
   logic [NS-1:0] car_req = '0, hall_up = '0, hall_dn = '0;
   logic [NS-1:0] car_pos;
   logic [6:0]    car_state;

   int n_chk = 0;
   int n_fail = 0;

   // reference model
   int m_fl, m_st, m_dir, m_cnt;   // dir: 0 none, 1 up, 2 down

   always #2 clk = ~clk;

   lift_car_ctrl uut (
      .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .svc_mode (svc_mode),
      .car_req (car_req), .hall_up (hall_up), .hall_dn (hall_dn),
      .car_pos (car_pos), .car_state (car_state)
   );

   function automatic bit allowed(int m, int i);
      int fl = i - 1;
      case (m)
         1: return (i <= 2) || (fl % 2 == 1);
         2: return (i < 2) || (fl > 0 && fl % 2 == 0);
         3: return i <= 11;
         4: return (i <= 2) || (i >= 11);
         default: return 1'b1;
      endcase
   endfunction

   function automatic bit any_over(logic [NS-1:0] v, int f);
      for (int j = f + 1; j < NS; j++) if (v[j]) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit any_under(logic [NS-1:0] v, int f);
      for (int j = 0; j < f; j++) if (v[j]) return 1'b1;
      return 1'b0;
   endfunction

   task automatic model_step();
      logic [NS-1:0] ec, eu, ed, all_r, hall;
      int nx;
      for (int i = 0; i < NS; i++) begin
         ec[i] = car_req[i] && allowed(svc_mode, i);
         eu[i] = hall_up[i] && allowed(svc_mode, i) && (i < NS - 1);
         ed[i] = hall_dn[i] && allowed(svc_mode, i) && (i > 0);
      end
      hall = eu | ed;
      all_r = ec | hall;
      nx = m_st;
      if (m_st == S_IDLE || (m_st == S_CLOSE && m_dir == 0)) begin
         if (ec[m_fl])                    nx = S_OPEN;
         else if (any_over(ec, m_fl))     nx = S_RISE;
         else if (ec != 0)                nx = S_FALL;
         else if (hall[m_fl])             nx = S_OPEN;
         else if (any_over(hall, m_fl))   nx = S_RISE;
         else if (hall != 0)              nx = S_FALL;
         else                             nx = S_IDLE;
      end else if (m_st == S_RISE || (m_st == S_CLOSE && m_dir == 1)) begin
         if (ec[m_fl] || eu[m_fl])        nx = (m_st == S_CLOSE) ? S_OPEN : S_RSTOP;
         else if (any_over(all_r, m_fl))  nx = S_RISE;
         else if (ed[m_fl])               nx = (m_st == S_CLOSE) ? S_OPEN : S_FSTOP;
         else if (any_under(all_r, m_fl)) nx = S_FALL;
         else                             nx = S_IDLE;
      end else if (m_st == S_FALL || m_st == S_CLOSE) begin
         if (ec[m_fl] || ed[m_fl])        nx = (m_st == S_CLOSE) ? S_OPEN : S_FSTOP;
         else if (any_under(all_r, m_fl)) nx = S_FALL;
         else if (eu[m_fl])               nx = (m_st == S_CLOSE) ? S_OPEN : S_RSTOP;
         else if (any_over(all_r, m_fl))  nx = S_RISE;
         else                             nx = S_IDLE;
      end else if (m_st == S_RSTOP || m_st == S_FSTOP) begin
         nx = S_OPEN;
      end else begin
         nx = (m_cnt == DT - 1) ? S_CLOSE : S_OPEN;
      end
      m_cnt = (m_st == S_OPEN) ? m_cnt + 1 : 0;
      if (nx == S_RISE || nx == S_RSTOP) m_dir = 1;
      else if (nx == S_FALL || nx == S_FSTOP) m_dir = 2;
      else if (nx == S_IDLE) m_dir = 0;
      if (nx == S_RISE && m_fl < NS - 1) m_fl++;
      if (nx == S_FALL && m_fl > 0) m_fl--;
      m_st = nx;
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one tick; inputs are stable; outputs compared against the model afterwards
   task automatic tick(string tag);
      @(negedge clk);
      model_step();
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      chk({tag, " pos"}, 32'(car_pos), 32'(1) << m_fl);
      chk({tag, " state"}, 32'(car_state), 32'(1) << m_st);
      repeat ($urandom % 3) @(negedge clk);
   endtask

   task automatic run_until(string tag, int st, int max_ticks);
      for (int k = 0; k < max_ticks; k++) begin
         if (car_state[st]) return;
         tick(tag);
      end
   endtask

   task automatic clear_all();
      car_req = '0; hall_up = '0; hall_dn = '0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      int open_ticks;
      void'($urandom(32'h1f2e3d4c));
      m_fl = 2; m_st = S_IDLE; m_dir = 0; m_cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      chk("R1 reset pos", 32'(car_pos), 32'h4);
      chk("R1 reset state", 32'(car_state), 32'h1);

      // R4 odd mode hides a request at floor 4 (bit 5)
      svc_mode = 3'd1; car_req[5] = 1'b1;
      repeat (3) tick("R4 odd mask");
      chk("R4 masked idle", 32'(car_state), 32'h1);
      // R4 high zone hides floor 9 (bit 10)
      clear_all(); svc_mode = 3'd4; hall_dn[10] = 1'b1;
      repeat (2) tick("R4 high mask");
      chk("R4 high zone idle", 32'(car_state), 32'h1);

      // R5 hall bits without buttons have no effect
      clear_all(); svc_mode = 3'd0; hall_up[21] = 1'b1; hall_dn[0] = 1'b1;
      repeat (3) tick("R5 ignored bits");
      chk("R5 still idle", 32'(car_state), 32'h1);
      chk("R5 still at floor 1", 32'(car_pos), 32'h4);

      // R7/R8 trip to floor 5 (bit 6)
      clear_all(); car_req[6] = 1'b1;
      run_until("R7 rise", S_RSTOP, 12);
      chk("R7 up-stop at floor 5", 32'(car_state), 32'(1) << S_RSTOP);
      tick("R7 stop to open");
      chk("R7 open after stop", 32'(car_state), 32'(1) << S_OPEN);
      car_req = '0;
      open_ticks = 0;
      while (car_state[S_OPEN] && open_ticks < 20) begin
         tick("R8 door");
         open_ticks++;
      end
      chk("R8 door-open ticks", 32'(open_ticks), 32'(DT));
      chk("R8 close follows", 32'(car_state), 32'(1) << S_CLOSE);

      // R9 nearer down call at floor 4, farther car request at floor 9
      hall_dn[5] = 1'b1; car_req[10] = 1'b1;
      tick("R9 keep direction");
      chk("R9 moves up", 32'(car_state), 32'(1) << S_RISE);
      chk("R9 position floor 6", 32'(car_pos), 32'(1) << 7);

      // R10 everything withdrawn while moving
      clear_all();
      tick("R10 nothing left");
      chk("R10 idle", 32'(car_state), 32'h1);
      tick("R10 stays idle");

      // R6 car request below beats hall call above
      car_req[3] = 1'b1; hall_up[15] = 1'b1;
      tick("R6 car first");
      chk("R6 moves down", 32'(car_state), 32'(1) << S_FALL);
      clear_all();
      tick("R6 clear");

      // R11 run to floor 20 and try to go further
      car_req[21] = 1'b1;
      run_until("R11 to top", S_OPEN, 40);
      car_req = '0;
      run_until("R11 close", S_IDLE, 20);
      chk("R11 at top", 32'(car_pos), 32'(1) << 21);
      hall_up[21] = 1'b1;
      repeat (3) tick("R11 top hold");
      chk("R11 no wrap", 32'(car_pos), 32'(1) << 21);
      clear_all();

      // random phase, every tick compared against the model (R2 R3 R7 R9 R10)
      for (int n = 0; n < 2500; n++) begin
         if ($urandom % 4 == 0) begin
            svc_mode = 3'($urandom % 8);
            for (int i = 0; i < NS; i++) begin
               car_req[i] = ($urandom % 20 == 0);
               hall_up[i] = ($urandom % 24 == 0);
               hall_dn[i] = ($urandom % 24 == 0);
            end
         end
         if ($urandom % 5 == 0) begin
            for (int i = 0; i < NS; i++) if (car_pos[i]) begin
               car_req[i] = 1'b0; hall_up[i] = 1'b0; hall_dn[i] = 1'b0;
            end
         end
         if ($urandom % 40 == 0) clear_all();
         tick("R2 random");
      end

      finish_run();
   end

endmodule